// File: doc/BRIEF.md
# Write-Through Cache with Random Replacement

This block is a unified instruction and data cache placed between a 32-bit processor core and a slower external memory bus. It holds 4 KB as 256 lines. Each line has four 32-bit words, one tag, a valid bit and a supervisor-only flag. The tags are fully associative. Reads are compared against every tag at once. A hit is answered in the same cycle the request is presented. A miss fetches the whole line from the bus, starting with the missed word and wrapping around the line. The core is released as soon as that first word arrives, and the other three words fill in behind it.

Stores always go out to the bus, and the core waits until the external write completes. There is no write-back and no write buffer. When a store hits, the cached word is also updated, byte by byte. The line that a fill overwrites is taken from a free-running counter. That counter advances every clock, so its value when a miss arrives is effectively random. No recency is tracked.

Three controls govern the cache:
- An enable input. After reset the block behaves as if this input were off.
- A per-access cacheable qualifier. An access marked non-cacheable does a single bus transfer with no lookup and no allocation.
- An invalidate pulse that drops every line at once, for use on a task switch.

The cache holds virtually addressed data, so each line remembers whether a supervisor access filled it. A user-mode read that matches such a line is sent to the bus as a single transfer.

Top module: `wt_cache`

## Requirements
- R1: While reset is held, and after it is released with no request, `mem_req` and `req_done` stay low.
- R2: With `cache_en` low, every read makes exactly one external read and allocates nothing. Enabling the cache afterwards and reading the same address causes a full line fill.
- R3: A cacheable read miss with the cache enabled makes exactly four external reads of the line. They start at word index `req_addr[3:2]` and step up by one modulo 4 (for example 2, 3, 0, 1). Each bus request holds its address until `mem_ack`.
- R4: On a miss, `req_done` rises in the cycle of the first `mem_ack` of the fill, carrying that word. This happens before the remaining three words have arrived.
- R5: A cacheable read that hits with the cache enabled completes in the cycle it is presented, with no external access, and returns the cached word.
- R6: Every write makes exactly one external write with the same byte address, byte enables and data. `req_done` stays low until the `mem_ack` of that write.
- R7: A write that hits updates the cached word: `req_be[n]` selects bits 8n+7 to 8n. A later read hit returns the merged word. A write that misses allocates no line.
- R8: A line filled by a supervisor read (`req_sup`=1) hits for supervisor reads. A user read (`req_sup`=0) that matches it makes one external read and allocates nothing.
- R9: A read with `req_cacheable` low makes one external read and returns bus data, even when the address is cached. The cached copy stays as it was.
- R10: A pulse on `inval` makes every line miss. If the pulse falls inside a fill, including the cycle of the fill's last `mem_ack`, the filled line is left invalid.
- R11: The cache holds at most 256 lines. Of 300 distinct lines filled in turn, at most 256 hit when they are read back, and the most recently filled line hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cache_en | input | 1 | Enables lookup and allocation |
| inval | input | 1 | One-cycle pulse that invalidates all lines |
| req_valid | input | 1 | Core request, held until `req_done` |
| req_write | input | 1 | 1 = store, 0 = load |
| req_sup | input | 1 | 1 = supervisor-mode access |
| req_cacheable | input | 1 | 0 = bypass the cache for this access |
| req_addr | input | 32 | Byte address |
| req_be | input | 4 | Byte enables of a store |
| req_wdata | input | 32 | Store data |
| req_done | output | 1 | Access completes at the next rising edge |
| req_rdata | output | 32 | Load data, valid with `req_done` |
| mem_req | output | 1 | External transfer request, held until `mem_ack` |
| mem_we | output | 1 | External transfer is a write |
| mem_addr | output | 32 | External byte address |
| mem_be | output | 4 | External byte enables |
| mem_wdata | output | 32 | External write data |
| mem_ack | input | 1 | External transfer completes this cycle |
| mem_rdata | input | 32 | External read data, valid with `mem_ack` |

## Verification
Two events can land in the same cycle: an invalidate pulse, and the final word of a line fill setting that line valid. The bench watches the bus acknowledges during a miss. It raises `inval` in exactly the cycle that carries the fourth acknowledge. It then reads the same address again and requires four fresh bus reads, which shows the invalidate won. A second case raises `inval` early in a fill, and a third pulses it while the cache is idle. Each case is judged by counting external reads at the ports.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SINGLE = 2'd1,
    ST_FILL   = 2'd2
  } wtc_state_e;
endpackage

// File: rtl/wtc_victim_ctr.sv
module wtc_victim_ctr #(
  parameter int IB = 8
) (
  input  logic          clk,
  input  logic          rst_i,
  output logic [IB-1:0] victim
);
  logic [IB-1:0] cnt_q;
  logic [IB-1:0] cnt_d;
  logic          cnt_en;

  assign cnt_en = 1'b1;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign victim = cnt_q;
endmodule

// File: rtl/wtc_tag_store.sv
module wtc_tag_store #(
  parameter int LINES = 256,
  parameter int TW    = 28,
  localparam int IB   = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst_i,
  input  logic          inval,
  input  logic          alloc,
  input  logic [IB-1:0] alloc_idx,
  input  logic [TW-1:0] alloc_tag,
  input  logic          alloc_sup,
  input  logic          commit,
  input  logic [IB-1:0] commit_idx,
  input  logic [TW-1:0] lk_tag,
  output logic          hit,
  output logic [IB-1:0] hit_idx,
  output logic          hit_sup
);
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] valid_d;
  logic [LINES-1:0] sup_q;
  logic [TW-1:0]    tag_q [LINES];
  logic [LINES-1:0] match;

  for (genvar i = 0; i < LINES; i++) begin : g_cmp
    assign match[i] = valid_q[i] && (tag_q[i] == lk_tag);
  end

  assign hit = |match;

  always_comb begin
    hit_idx = '0;
    hit_sup = 1'b0;
    for (int i = 0; i < LINES; i++) begin
      if (match[i]) begin
        hit_idx = hit_idx | IB'(i);
        hit_sup = hit_sup | sup_q[i];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < LINES; i++) begin
      if (inval)                                valid_d[i] = 1'b0;
      else if (alloc && (alloc_idx == IB'(i)))  valid_d[i] = 1'b0;
      else if (commit && (commit_idx == IB'(i))) valid_d[i] = 1'b1;
      else                                      valid_d[i] = valid_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (alloc) begin
      tag_q[alloc_idx] <= alloc_tag;
      sup_q[alloc_idx] <= alloc_sup;
    end
  end

  AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_i)
    $onehot0(match)); // R8
  AST_INVAL_EMPTY: assert property (@(posedge clk) disable iff (!rst_i)
    inval |=> (match == '0)); // R10
endmodule

// File: rtl/wtc_data_store.sv
module wtc_data_store #(
  parameter int LINES = 256,
  parameter int WORDS = 4,
  parameter int DW    = 32,
  localparam int IB   = $clog2(LINES),
  localparam int WB   = $clog2(WORDS),
  localparam int BW   = DW / 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IB-1:0] widx,
  input  logic [WB-1:0] wword,
  input  logic [BW-1:0] wbe,
  input  logic [DW-1:0] wdata,
  input  logic [IB-1:0] ridx,
  input  logic [WB-1:0] rword,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem_q [LINES*WORDS];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int b = 0; b < BW; b++) begin
        if (wbe[b]) mem_q[{widx, wword}][8*b +: 8] <= wdata[8*b +: 8];
      end
    end
  end

  assign rdata = mem_q[{ridx, rword}];
endmodule

// File: rtl/wt_cache.sv
module wt_cache
  import wtc_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int LINES = 256,
  parameter int WORDS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cache_en,
  input  logic            inval,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic            req_sup,
  input  logic            req_cacheable,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW/8-1:0] req_be,
  input  logic [DW-1:0]   req_wdata,
  output logic            req_done,
  output logic [DW-1:0]   req_rdata,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW/8-1:0] mem_be,
  output logic [DW-1:0]   mem_wdata,
  input  logic            mem_ack,
  input  logic [DW-1:0]   mem_rdata
);
  localparam int BW = DW / 8;
  localparam int OB = $clog2(BW);
  localparam int WB = $clog2(WORDS);
  localparam int IB = $clog2(LINES);
  localparam int TW = AW - OB - WB;

  // reset: asserted at once, released through two flops
  logic [1:0] rs_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  wtc_state_e    st_q, st_d;
  logic [WB-1:0] beat_q, beat_d;
  logic          kill_q, kill_d;
  logic [AW-1:0] addr_q;
  logic          we_q, upd_q;
  logic [BW-1:0] be_q;
  logic [DW-1:0] wdata_q;
  logic [IB-1:0] idx_q;

  logic [TW-1:0] req_tag;
  logic [WB-1:0] req_word, fword;
  logic          lookup, hit, hit_sup, sup_block;
  logic [IB-1:0] hit_idx, victim;
  logic [DW-1:0] hit_data;
  logic          idle_acc, rd_hit, start_fill, start_single, cap_en;
  logic          in_fill, fill_ack, last_beat, commit;
  logic          dwe;
  logic [WB-1:0] dword;
  logic [BW-1:0] dbe;
  logic [DW-1:0] dwdata;

  assign req_tag  = req_addr[AW-1 -: TW];
  assign req_word = req_addr[OB +: WB];
  assign lookup   = cache_en && req_cacheable;
  assign fword    = addr_q[OB +: WB] + beat_q;

  wtc_victim_ctr #(.IB(IB)) u_victim (
    .clk(clk), .rst_i(rst_i), .victim(victim)
  );

  assign sup_block    = hit && hit_sup && !req_sup;
  assign idle_acc     = (st_q == ST_IDLE) && req_valid;
  assign rd_hit       = idle_acc && !req_write && lookup && hit && !sup_block;
  assign start_fill   = idle_acc && !req_write && lookup && !hit;
  assign start_single = idle_acc && !rd_hit && !start_fill;
  assign cap_en       = start_fill || start_single;
  assign in_fill      = (st_q == ST_FILL);
  assign fill_ack     = in_fill && mem_ack;
  assign last_beat    = (beat_q == WB'(WORDS - 1));
  assign commit       = fill_ack && last_beat && !kill_q;

  wtc_tag_store #(.LINES(LINES), .TW(TW)) u_tags (
    .clk(clk), .rst_i(rst_i), .inval(inval),
    .alloc(start_fill), .alloc_idx(victim), .alloc_tag(req_tag),
    .alloc_sup(req_sup), .commit(commit), .commit_idx(idx_q),
    .lk_tag(req_tag), .hit(hit), .hit_idx(hit_idx), .hit_sup(hit_sup)
  );

  assign dwe    = fill_ack || ((st_q == ST_SINGLE) && mem_ack && upd_q);
  assign dword  = in_fill ? fword : addr_q[OB +: WB];
  assign dbe    = in_fill ? {BW{1'b1}} : be_q;
  assign dwdata = in_fill ? mem_rdata : wdata_q;

  wtc_data_store #(.LINES(LINES), .WORDS(WORDS), .DW(DW)) u_data (
    .clk(clk), .we(dwe), .widx(idx_q), .wword(dword), .wbe(dbe),
    .wdata(dwdata), .ridx(hit_idx), .rword(req_word), .rdata(hit_data)
  );

  // next state
  always_comb begin
    st_d   = st_q;
    beat_d = beat_q;
    kill_d = kill_q;
    unique case (st_q)
      ST_IDLE: begin
        beat_d = '0;
        kill_d = inval;
        if (start_fill)        st_d = ST_FILL;
        else if (start_single) st_d = ST_SINGLE;
      end
      ST_SINGLE: begin
        if (mem_ack) st_d = ST_IDLE;
      end
      ST_FILL: begin
        kill_d = kill_q || inval;
        if (mem_ack) begin
          beat_d = beat_q + 1'b1;
          if (last_beat) st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st_q   <= ST_IDLE;
      beat_q <= '0;
      kill_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      beat_q <= beat_d;
      kill_q <= kill_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      addr_q  <= req_addr;
      we_q    <= req_write;
      be_q    <= req_be;
      wdata_q <= req_wdata;
      upd_q   <= req_write && lookup && hit;
      idx_q   <= start_fill ? victim : hit_idx;
    end
  end

  assign req_done  = rd_hit || ((st_q == ST_SINGLE) && mem_ack) ||
                     (fill_ack && (beat_q == '0));
  assign req_rdata = rd_hit ? hit_data : mem_rdata;
  assign mem_req   = (st_q != ST_IDLE);
  assign mem_we    = (st_q == ST_SINGLE) && we_q;
  assign mem_addr  = in_fill ? {addr_q[AW-1:OB+WB], fword, {OB{1'b0}}} : addr_q;
  assign mem_be    = (in_fill || !we_q) ? {BW{1'b1}} : be_q;
  assign mem_wdata = wdata_q;

  AST_WRITE_STALL: assert property (@(posedge clk) disable iff (!rst_i)
    (mem_req && mem_we && !mem_ack) |-> !req_done); // R6
  AST_BUS_HELD: assert property (@(posedge clk) disable iff (!rst_i)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R3
  AST_FILL_WRAP: assert property (@(posedge clk) disable iff (!rst_i)
    (in_fill && mem_ack && !last_beat) |=>
      (mem_addr[OB +: WB] == $past(mem_addr[OB +: WB]) + 1'b1)); // R3
  AST_DISABLED_NO_HIT: assert property (@(posedge clk) disable iff (!rst_i)
    ((st_q == ST_IDLE) && req_valid && !cache_en) |-> !req_done); // R2
  AST_USER_BLOCKED: assert property (@(posedge clk) disable iff (!rst_i)
    ((st_q == ST_IDLE) && req_valid && !req_write && !req_sup && hit && hit_sup)
      |-> !req_done); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_i)
    (!$past(req_valid) && !req_valid && (st_q == ST_IDLE)) |-> (!mem_req && !req_done)); // R1
endmodule

// File: tb/wt_cache_tb.sv
module wt_cache_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cache_en = 1'b0, inval = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_sup = 1'b0, req_cacheable = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic        req_done, mem_req, mem_we;
  logic [31:0] req_rdata, mem_addr, mem_wdata;
  logic [3:0]  mem_be;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  int checks = 0, errors = 0, cyc_cnt = 0;
  int n_rd = 0, n_wr = 0, wcnt = 0;
  logic [31:0] rd_log [4];
  logic [31:0] wr_addr_last, wr_data_last;
  logic [3:0]  wr_be_last;
  logic [31:0] wm [int unsigned];

  always #10 clk = ~clk;

  wt_cache u_dut (
    .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .inval(inval),
    .req_valid(req_valid), .req_write(req_write), .req_sup(req_sup),
    .req_cacheable(req_cacheable), .req_addr(req_addr), .req_be(req_be),
    .req_wdata(req_wdata), .req_done(req_done), .req_rdata(req_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] model_rd(input logic [31:0] a);
    int unsigned k = a[31:2];
    if (wm.exists(k)) return wm[k];
    return {a[31:2], 2'b00} ^ 32'h5A5A_0F0F;
  endfunction

  // external memory: acknowledges on the second edge of a held request
  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      if (wcnt == 1) begin
        wcnt = 0;
        mem_ack <= 1'b1;
        if (mem_we) begin
          logic [31:0] v;
          v = model_rd(mem_addr);
          for (int b = 0; b < 4; b++) if (mem_be[b]) v[8*b +: 8] = mem_wdata[8*b +: 8];
          wm[mem_addr[31:2]] = v;
          wr_addr_last = mem_addr; wr_data_last = mem_wdata; wr_be_last = mem_be;
          n_wr++;
        end else begin
          mem_rdata <= model_rd(mem_addr);
          rd_log[n_rd % 4] = mem_addr;
          n_rd++;
        end
      end else wcnt++;
    end else mem_ack <= 1'b0;
  end

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 150000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc_cnt, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic acc(input bit we, input bit sup, input bit cch, input logic [31:0] a,
                     input logic [3:0] be, input logic [31:0] wd,
                     output logic [31:0] rd, output int cyc);
    req_write = we; req_sup = sup; req_cacheable = cch;
    req_addr = a; req_be = be; req_wdata = wd; req_valid = 1'b1;
    cyc = 0;
    while (1) begin
      #2;
      if (req_done) break;
      @(negedge clk);
      cyc++;
      if (cyc > 200) begin
        chk(1'b0, "access timeout", 32'(cyc), 32'd200);
        break;
      end
    end
    rd = req_rdata;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (mem_req) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(!mem_req && !req_done, "R1 reset quiet", {mem_req, req_done}, 32'd0);
    repeat (3) @(negedge clk);
    chk(!mem_req && !req_done, "R1 idle after reset", {mem_req, req_done}, 32'd0);
  endtask

  task automatic t_disabled();
    logic [31:0] d; int c, s;
    cache_en = 1'b0;
    for (int k = 0; k < 2; k++) begin
      s = n_rd;
      acc(0, 1, 1, 32'h0000_0700, 4'hF, 0, d, c);
      chk(n_rd - s == 1, "R2 one bus read when disabled", 32'(n_rd - s), 32'd1);
      chk(d == model_rd(32'h700), "R2 data when disabled", d, model_rd(32'h700));
    end
    cache_en = 1'b1;
    s = n_rd;
    acc(0, 1, 1, 32'h0000_0700, 4'hF, 0, d, c);
    wait_idle();
    chk(n_rd - s == 4, "R2 no allocation while disabled", 32'(n_rd - s), 32'd4);
  endtask

  task automatic t_fill();
    logic [31:0] d; int c, s;
    s = n_rd;
    acc(0, 1, 1, 32'h0000_1008, 4'hF, 0, d, c);
    chk(n_rd - s == 1, "R4 released after first beat", 32'(n_rd - s), 32'd1);
    chk(d == model_rd(32'h1008), "R4 critical word data", d, model_rd(32'h1008));
    wait_idle();
    chk(n_rd - s == 4, "R3 four beats", 32'(n_rd - s), 32'd4);
    for (int k = 0; k < 4; k++) begin
      logic [31:0] e;
      e = 32'h1000 | (32'((2 + k) % 4) << 2);
      chk(rd_log[(s + k) % 4] == e, "R3 wrap order", rd_log[(s + k) % 4], e);
    end
  endtask

  task automatic t_hit();
    logic [31:0] d; int c, s;
    s = n_rd;
    acc(0, 1, 1, 32'h0000_1000, 4'hF, 0, d, c);
    chk(c == 0 && n_rd == s, "R5 hit same cycle no bus", 32'(c), 32'd0);
    chk(d == model_rd(32'h1000), "R5 hit data", d, model_rd(32'h1000));
    acc(0, 1, 1, 32'h0000_100C, 4'hF, 0, d, c);
    chk(c == 0 && d == model_rd(32'h100C), "R5 hit last word", d, model_rd(32'h100C));
  endtask

  task automatic t_write();
    logic [31:0] d, old, e; int c, s, sw;
    acc(0, 1, 1, 32'h0000_2404, 4'hF, 0, old, c);
    wait_idle();
    sw = n_wr;
    acc(1, 1, 1, 32'h0000_2404, 4'b0011, 32'hDEAD_BEEF, d, c);
    chk(n_wr - sw == 1, "R6 one bus write", 32'(n_wr - sw), 32'd1);
    chk(wr_addr_last == 32'h2404 && wr_be_last == 4'b0011, "R6 write addr/be",
        wr_addr_last, 32'h2404);
    chk(wr_data_last == 32'hDEAD_BEEF, "R6 write data", wr_data_last, 32'hDEAD_BEEF);
    chk(c >= 2, "R6 core stalled for write", 32'(c), 32'd2);
    e = {old[31:16], 16'hBEEF};
    s = n_rd;
    acc(0, 1, 1, 32'h0000_2404, 4'hF, 0, d, c);
    chk(n_rd == s && d == e, "R7 merged hit after write", d, e);
    acc(1, 1, 1, 32'h0000_2800, 4'hF, 32'h1234_5678, d, c);
    s = n_rd;
    acc(0, 1, 1, 32'h0000_2800, 4'hF, 0, d, c);
    wait_idle();
    chk(n_rd - s == 4, "R7 write miss not allocated", 32'(n_rd - s), 32'd4);
    chk(d == 32'h1234_5678, "R7 data after write miss", d, 32'h1234_5678);
  endtask

  task automatic t_sup();
    logic [31:0] d; int c, s;
    acc(0, 1, 1, 32'h0000_3000, 4'hF, 0, d, c);
    wait_idle();
    for (int k = 0; k < 2; k++) begin
      s = n_rd;
      acc(0, 0, 1, 32'h0000_3004, 4'hF, 0, d, c);
      wait_idle();
      chk(n_rd - s == 1, "R8 user read of supervisor line", 32'(n_rd - s), 32'd1);
      chk(d == model_rd(32'h3004), "R8 user data", d, model_rd(32'h3004));
      s = n_rd;
      acc(0, 1, 1, 32'h0000_3004, 4'hF, 0, d, c);
      chk(n_rd == s && c == 0, "R8 supervisor still hits", 32'(n_rd - s), 32'd0);
    end
  endtask

  task automatic t_noncache();
    logic [31:0] d, old; int c, s;
    acc(0, 1, 1, 32'h0000_6000, 4'hF, 0, old, c);
    wait_idle();
    wm[32'h6000 >> 2] = 32'hCAFE_0001;
    s = n_rd;
    acc(0, 1, 0, 32'h0000_6000, 4'hF, 0, d, c);
    chk(n_rd - s == 1 && d == 32'hCAFE_0001, "R9 bypass reads bus", d, 32'hCAFE_0001);
    s = n_rd;
    acc(0, 1, 1, 32'h0000_6000, 4'hF, 0, d, c);
    chk(n_rd == s && d == old, "R9 cached copy untouched", d, old);
  endtask

  task automatic t_inval();
    logic [31:0] d; int c, s;
    acc(0, 1, 1, 32'h0000_7000, 4'hF, 0, d, c);
    wait_idle();
    inval = 1'b1; @(negedge clk); inval = 1'b0;
    s = n_rd;
    acc(0, 1, 1, 32'h0000_7000, 4'hF, 0, d, c);
    wait_idle();
    chk(n_rd - s == 4, "R10 idle invalidate", 32'(n_rd - s), 32'd4);
    // invalidate in the cycle of the fill's last acknowledge
    s = n_rd;
    acc(0, 1, 1, 32'h0000_4000, 4'hF, 0, d, c);
    while (!(mem_ack && (n_rd == s + 4))) @(negedge clk);
    inval = 1'b1; @(negedge clk); inval = 1'b0;
    wait_idle();
    s = n_rd;
    acc(0, 1, 1, 32'h0000_4000, 4'hF, 0, d, c);
    wait_idle();
    chk(n_rd - s == 4, "R10 invalidate on last beat wins", 32'(n_rd - s), 32'd4);
    // invalidate early in a fill
    s = n_rd;
    acc(0, 1, 1, 32'h0000_5000, 4'hF, 0, d, c);
    inval = 1'b1; @(negedge clk); inval = 1'b0;
    wait_idle();
    s = n_rd;
    acc(0, 1, 1, 32'h0000_5000, 4'hF, 0, d, c);
    wait_idle();
    chk(n_rd - s == 4, "R10 invalidate mid fill", 32'(n_rd - s), 32'd4);
  endtask

  task automatic t_capacity();
    logic [31:0] d; int c, s, hits;
    for (int i = 0; i < 300; i++) begin
      acc(0, 1, 1, 32'h0001_0000 + 32'(i) * 16, 4'hF, 0, d, c);
      wait_idle();
    end
    hits = 0;
    for (int i = 299; i >= 0; i--) begin
      s = n_rd;
      acc(0, 1, 1, 32'h0001_0000 + 32'(i) * 16, 4'hF, 0, d, c);
      wait_idle();
      if (n_rd == s) hits++;
      if (i == 299) chk(n_rd == s, "R11 newest line present", 32'(n_rd - s), 32'd0);
    end
    chk(hits <= 256, "R11 at most 256 lines held", 32'(hits), 32'd256);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_disabled();
    t_fill();
    t_hit();
    t_write();
    t_sup();
    t_noncache();
    t_inval();
    t_capacity();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule